// File: doc/BRIEF.md
# Command-Bus Window Slot Allocator

This block hands out issue slots on a command bus that several DRAM sequencers share. Time is split into aligned command windows of `2**WIN_LOG2` time units, and each window carries at most `MAX_CMDS` commands. Row-type and column-type commands draw on two separate pools with the same limit. A requester presents the time at which it would like to issue and says whether the command is a row or a column command. One cycle later the block returns either the time it may actually issue, or a refusal.

When the window that holds the desired time already carries its full share, the request slides forward one whole window at a time. It lands on the start of the first window that still has room. Occupancy is kept in a small circular table per pool, indexed by window number modulo `NUM_WIN`. Each entry carries the window number it belongs to, so counts from windows that are already behind the current time read as empty and are recycled without an explicit sweep. The current time is an input and must never decrease.

Top module: `cmd_slot_alloc`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `gnt_valid` and `gnt_ok` are 0 and every window of both pools is empty.
- R2: A request sampled with `req_valid`=1 on a rising edge produces exactly one `gnt_valid`=1 cycle, in the next cycle. `gnt_valid` is 0 in every cycle that follows a cycle without a request.
- R3: The effective desired time is the larger of `req_time` and `cur_time`. If its window holds fewer than `MAX_CMDS` commands of the requested pool, the grant has `gnt_ok`=1 and `gnt_time` equal to the effective desired time.
- R4: If that window is full, the candidate advances one window at a time, skipping any number of full windows. The grant is the start of the first window with room, which is window number times `2**WIN_LOG2`, so its low `WIN_LOG2` bits are zero.
- R5: Every grant adds one to the count of its window in its pool. No window ever receives more than `MAX_CMDS` grants of one pool.
- R6: `req_row`=1 selects the row pool and `req_row`=0 selects the column pool. Grants in one pool never change what the other pool grants.
- R7: A `req_time` earlier than `cur_time` is served as if it had asked for `cur_time`.
- R8: If the effective desired window is `NUM_WIN` or more windows beyond the window of `cur_time`, the request is refused and no count changes.
- R9: A refused request returns `gnt_ok`=0 and `gnt_time`=0. A refusal also happens when every window from the candidate up to window `cur_window+NUM_WIN-1` is full.
- R10: Counts kept for windows before the window of `cur_time` are discarded. A later window that shares their table slot starts empty.
- R11: A granted time is never earlier than the effective desired time. It also never lies beyond the last tracked window, `cur_window+NUM_WIN-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_time | input | TIME_W | Present time, never decreasing |
| req_valid | input | 1 | A request is presented this cycle |
| req_row | input | 1 | 1 = row command pool, 0 = column command pool |
| req_time | input | TIME_W | Desired issue time |
| gnt_valid | output | 1 | Response for the previous cycle's request |
| gnt_ok | output | 1 | 1 = slot granted, 0 = refused |
| gnt_time | output | TIME_W | Granted issue time, 0 when refused |

## Verification
Every result of this block is due exactly one clock edge after its request: the grant flag, the granted time and the refusal all leave the same output register. The occupancy update also lands on that same edge, so a request in the very next cycle already sees it. The bench applies a request together with `cur_time` on a falling edge. It compares the outputs on the following falling edge, after the single register stage has loaded. At that same moment it applies the next request, so back-to-back requests are checked against a model that has also committed each grant before the next one.

// File: rtl/cmdslot_pkg.sv
package cmdslot_pkg;

    localparam int DEF_TIME_W   = 20;
    localparam int DEF_WIN_LOG2 = 2;
    localparam int DEF_NUM_WIN  = 4;
    localparam int DEF_MAX_CMDS = 2;
    localparam int NUM_POOLS    = 2;

    typedef enum logic {
        POOL_COL = 1'b0,
        POOL_ROW = 1'b1
    } pool_e;

    function automatic int cnt_width(input int max_cmds);
        return $clog2(max_cmds + 1);
    endfunction

endpackage

// File: rtl/cmdslot_table.sv
module cmdslot_table
    import cmdslot_pkg::*;
#(
    parameter int NUM_WIN = DEF_NUM_WIN,
    parameter int WIN_W   = 18,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  pool_e            wr_pool,
    input  logic [WIN_W-1:0] wr_win,
    output logic [WIN_W-1:0] tag_o [NUM_POOLS][NUM_WIN],
    output logic [CNT_W-1:0] cnt_o [NUM_POOLS][NUM_WIN]
);

    localparam int IDX_W = $clog2(NUM_WIN);

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        for (genvar e = 0; e < NUM_WIN; e++) begin : g_ent
            logic [WIN_W-1:0] tag_q;
            logic [CNT_W-1:0] cnt_q;
            logic             hit;

            assign hit = wr_en && (wr_pool == pool_e'(p))
                         && (wr_win[IDX_W-1:0] == IDX_W'(e));

            always_ff @(posedge clk) begin
                if (rst) begin
                    tag_q <= '0;
                    cnt_q <= '0;
                end else if (hit) begin
                    if (tag_q == wr_win) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end else begin
                        tag_q <= wr_win;
                        cnt_q <= CNT_W'(1);
                    end
                end
            end

            assign tag_o[p][e] = tag_q;
            assign cnt_o[p][e] = cnt_q;
        end
    end

endmodule

// File: rtl/cmdslot_search.sv
module cmdslot_search #(
    parameter int TIME_W   = 20,
    parameter int WIN_LOG2 = 2,
    parameter int NUM_WIN  = 4,
    parameter int MAX_CMDS = 2,
    parameter int CNT_W    = 2
) (
    input  logic [TIME_W-1:0]          cur_time,
    input  logic [TIME_W-1:0]          req_time,
    input  logic [TIME_W-WIN_LOG2-1:0] tag_i [NUM_WIN],
    input  logic [CNT_W-1:0]           cnt_i [NUM_WIN],
    output logic                       found,
    output logic [TIME_W-WIN_LOG2-1:0] grant_win,
    output logic [TIME_W-1:0]          grant_time
);

    localparam int WIN_W = TIME_W - WIN_LOG2;
    localparam int IDX_W = $clog2(NUM_WIN);

    logic [TIME_W-1:0] eff_time;
    logic [WIN_W-1:0]  eff_win;
    logic [WIN_W-1:0]  cur_win;
    logic [WIN_W-1:0]  cand;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  occ;
    logic              first_hit;

    always_comb begin
        eff_time  = (req_time < cur_time) ? cur_time : req_time;
        eff_win   = eff_time[TIME_W-1:WIN_LOG2];
        cur_win   = cur_time[TIME_W-1:WIN_LOG2];
        found     = 1'b0;
        first_hit = 1'b0;
        grant_win = eff_win;
        cand      = eff_win;
        idx       = '0;
        occ       = '0;
        if ((eff_win - cur_win) < WIN_W'(NUM_WIN)) begin
            for (int k = 0; k < NUM_WIN; k++) begin
                cand = eff_win + WIN_W'(k);
                idx  = cand[IDX_W-1:0];
                occ  = (tag_i[idx] == cand) ? cnt_i[idx] : '0;
                if (!found && ((cand - cur_win) < WIN_W'(NUM_WIN))
                    && (occ < CNT_W'(MAX_CMDS))) begin
                    found     = 1'b1;
                    grant_win = cand;
                    first_hit = (k == 0);
                end
            end
        end
        if (!found)
            grant_time = '0;
        else if (first_hit)
            grant_time = eff_time;
        else
            grant_time = {grant_win, {WIN_LOG2{1'b0}}};
    end

endmodule

// File: rtl/cmd_slot_alloc.sv
module cmd_slot_alloc
    import cmdslot_pkg::*;
#(
    parameter int TIME_W   = DEF_TIME_W,
    parameter int WIN_LOG2 = DEF_WIN_LOG2,
    parameter int NUM_WIN  = DEF_NUM_WIN,
    parameter int MAX_CMDS = DEF_MAX_CMDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              req_valid,
    input  logic              req_row,
    input  logic [TIME_W-1:0] req_time,
    output logic              gnt_valid,
    output logic              gnt_ok,
    output logic [TIME_W-1:0] gnt_time
);

    localparam int WIN_W = TIME_W - WIN_LOG2;
    localparam int CNT_W = cnt_width(MAX_CMDS);

    logic [WIN_W-1:0]  tag_all [NUM_POOLS][NUM_WIN];
    logic [CNT_W-1:0]  cnt_all [NUM_POOLS][NUM_WIN];
    logic [WIN_W-1:0]  tag_sel [NUM_WIN];
    logic [CNT_W-1:0]  cnt_sel [NUM_WIN];
    logic              found;
    logic [WIN_W-1:0]  grant_win;
    logic [TIME_W-1:0] grant_time;
    pool_e             pool;

    assign pool = req_row ? POOL_ROW : POOL_COL;

    always_comb begin
        for (int e = 0; e < NUM_WIN; e++) begin
            tag_sel[e] = tag_all[int'(pool)][e];
            cnt_sel[e] = cnt_all[int'(pool)][e];
        end
    end

    cmdslot_table #(
        .NUM_WIN (NUM_WIN),
        .WIN_W   (WIN_W),
        .CNT_W   (CNT_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req_valid && found),
        .wr_pool (pool),
        .wr_win  (grant_win),
        .tag_o   (tag_all),
        .cnt_o   (cnt_all)
    );

    cmdslot_search #(
        .TIME_W   (TIME_W),
        .WIN_LOG2 (WIN_LOG2),
        .NUM_WIN  (NUM_WIN),
        .MAX_CMDS (MAX_CMDS),
        .CNT_W    (CNT_W)
    ) u_search (
        .cur_time   (cur_time),
        .req_time   (req_time),
        .tag_i      (tag_sel),
        .cnt_i      (cnt_sel),
        .found      (found),
        .grant_win  (grant_win),
        .grant_time (grant_time)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_valid <= 1'b0;
            gnt_ok    <= 1'b0;
            gnt_time  <= '0;
        end else begin
            gnt_valid <= req_valid;
            gnt_ok    <= req_valid && found;
            gnt_time  <= (req_valid && found) ? grant_time : '0;
        end
    end

endmodule

// File: rtl/cmd_slot_alloc_chk.sv
module cmd_slot_alloc_chk #(
    parameter int TIME_W   = 20,
    parameter int WIN_LOG2 = 2,
    parameter int NUM_WIN  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [TIME_W-1:0] cur_time,
    input logic              req_valid,
    input logic [TIME_W-1:0] req_time,
    input logic              gnt_valid,
    input logic              gnt_ok,
    input logic [TIME_W-1:0] gnt_time
);

    localparam int WIN_W = TIME_W - WIN_LOG2;

    logic [WIN_W-1:0] req_win_c;
    logic [WIN_W-1:0] cur_win_c;
    logic             far_req;

    assign req_win_c = req_time[TIME_W-1:WIN_LOG2];
    assign cur_win_c = cur_time[TIME_W-1:WIN_LOG2];
    assign far_req   = req_win_c >= (cur_win_c + WIN_W'(NUM_WIN));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!gnt_valid && !gnt_ok));

    assert_grant_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> gnt_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !gnt_valid);

    assert_shift_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        (gnt_ok && ($past(req_time) >= $past(cur_time))
         && (gnt_time != $past(req_time)))
        |-> (gnt_time[WIN_LOG2-1:0] == '0));

    assert_far_reject_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && far_req) |=> (gnt_valid && !gnt_ok));

    assert_reject_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !gnt_ok) |-> (gnt_time == '0));

    assert_not_early_R11: assert property (@(posedge clk) disable iff (rst)
        gnt_ok |-> ((gnt_time >= $past(req_time))
                    && (gnt_time >= $past(cur_time))));

    assert_in_range_R11: assert property (@(posedge clk) disable iff (rst)
        gnt_ok |-> (gnt_time[TIME_W-1:WIN_LOG2]
                    < ($past(cur_time[TIME_W-1:WIN_LOG2]) + WIN_W'(NUM_WIN))));

endmodule

bind cmd_slot_alloc cmd_slot_alloc_chk #(
    .TIME_W   (TIME_W),
    .WIN_LOG2 (WIN_LOG2),
    .NUM_WIN  (NUM_WIN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cur_time  (cur_time),
    .req_valid (req_valid),
    .req_time  (req_time),
    .gnt_valid (gnt_valid),
    .gnt_ok    (gnt_ok),
    .gnt_time  (gnt_time)
);

// File: tb/tb_cmd_slot_alloc.sv
`timescale 1ns/1ps
module tb_cmd_slot_alloc;

    localparam int TW   = 20;
    localparam int WSZ  = 4;
    localparam int NW   = 4;
    localparam int MAXC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] cur_time = '0;
    logic          req_valid = 1'b0;
    logic          req_row = 1'b0;
    logic [TW-1:0] req_time = '0;
    logic          gnt_valid;
    logic          gnt_ok;
    logic [TW-1:0] gnt_time;

    always #2 clk = ~clk;

    cmd_slot_alloc #(
        .TIME_W(TW), .WIN_LOG2(2), .NUM_WIN(NW), .MAX_CMDS(MAXC)
    ) dut (
        .clk(clk), .rst(rst), .cur_time(cur_time),
        .req_valid(req_valid), .req_row(req_row), .req_time(req_time),
        .gnt_valid(gnt_valid), .gnt_ok(gnt_ok), .gnt_time(gnt_time)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    int    now = 0;
    int    mcnt [int];
    bit    exp_v = 0;
    bit    exp_ok = 0;
    int    exp_t = 0;
    string exp_tag = "R1";

    task automatic check_out();
        n_chk++;
        if (gnt_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s gnt_valid got %0b expected %0b", exp_tag, gnt_valid, exp_v);
        end
        if (exp_v) begin
            n_chk++;
            if (gnt_ok !== exp_ok || int'(gnt_time) != exp_t) begin
                n_fail++;
                $display("FAIL %s grant got ok=%0b time=%0d expected ok=%0b time=%0d",
                         exp_tag, gnt_ok, gnt_time, exp_ok, exp_t);
            end
        end
    endtask

    // one request per cycle; outputs of the previous one are checked first
    task automatic step(input bit v, input bit row, input int t, input string tag);
        int eff, ew, cw, key;
        @(negedge clk);
        check_out();
        cur_time  = TW'(now);
        req_valid = v;
        req_row   = row;
        req_time  = TW'(t);
        exp_v = v; exp_ok = 0; exp_t = 0; exp_tag = tag;
        if (v) begin
            eff = (t < now) ? now : t;
            ew  = eff / WSZ;
            cw  = now / WSZ;
            if (ew - cw < NW) begin
                for (int w = ew; w < cw + NW; w++) begin
                    key = (row ? 1000000 : 0) + w;
                    if (!mcnt.exists(key)) mcnt[key] = 0;
                    if (!exp_ok && mcnt[key] < MAXC) begin
                        exp_ok = 1;
                        exp_t  = (w == ew) ? eff : w * WSZ;
                        mcnt[key]++;
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int off;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: quiet right after reset
        step(0, 0, 0, "R1");
        step(0, 0, 0, "R2");
        // R3: free windows grant the desired time itself
        step(1, 1, 5, "R3");
        step(1, 1, 6, "R3");
        // R4: window 1 full -> 8; then 9; then 5 skips windows 1,2 -> 12
        step(1, 1, 7, "R4");
        step(1, 1, 9, "R4");
        step(1, 1, 5, "R4");
        // R6: column pool unaffected by full row windows
        step(1, 0, 5, "R6");
        step(1, 0, 6, "R6");
        // R5/R9: window 3 filled, then nothing left in range -> refusal
        step(1, 1, 13, "R5");
        step(1, 1, 14, "R9");
        step(0, 0, 0, "R2");
        // R8: four windows ahead is refused
        step(1, 0, 16, "R8");
        step(1, 0, 3, "R8");
        // R7: time moves to 20 (window 5); past request served at 20
        now = 20;
        step(1, 1, 3, "R7");
        // R10: window 5 reuses slot of full window 1, window 6 that of window 2
        step(1, 1, 21, "R10");
        step(1, 1, 22, "R10");
        step(1, 1, 25, "R10");
        // mixed traffic against the model
        seed = 32'd7;
        for (int i = 0; i < 300; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            off  = int'((seed >> 8) % 24) - 4;
            step(((seed >> 3) & 3) != 0, seed[20], (now + off < 0) ? 0 : now + off, "R5");
            now = now + int'((seed >> 12) % 3);
        end
        step(0, 0, 0, "R2");
        step(0, 0, 0, "R2");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule